// File: doc/BRIEF.md
# NAND Flash Address Phase Sequencer

This block produces the address phase on an 8-bit small-page NAND flash bus. A host hands it a byte offset into the device, a mode that says whether a column byte, page bytes or both are to be sent, a page-size select (256 or 512 bytes), and the number of page address bytes the attached device expects. The sequencer then raises the address latch enable and sends one byte per write-enable pulse. It drops the latch enable after the last byte and waits for the ready/busy line to show ready. Only then does it report completion.

For 512-byte pages, offset bit 8 does not travel as an address bit. It tells the host which read command to issue: the one for the first half of the page or the one for the second half. The sequencer reports that choice on its own output and keeps it until the next accepted request. Issuing commands, moving data and error correction belong to other blocks.

Top module: `nand_addr_seq`

## Requirements
- R1: `ale` is high during every cycle of an address phase, from the first byte through the last, and low at all other times. `we_n` pulses low only while `ale` is high.
- R2: Each address byte is sent with one `we_n` low pulse lasting exactly `STROBE_CLKS` clocks, followed by a high time of the same length. `io` holds the byte during both parts.
- R3: When `mode` bit 0 is set (encoding 01 = column only, 11 = column then page), the first byte sent is `ofs[7:0]`.
- R4: The page number is `ofs >> 8` when `big_page` is 0 (256-byte page) and `ofs >> 9` when `big_page` is 1 (512-byte page).
- R5: When `mode` bit 1 is set (10 = page only, 11 = column then page), `page_bytes` page address bytes follow, least-significant byte of the page number first, each byte taking the next 8 bits. `page_bytes` values 1 to 3 are used as given, and 0 is treated as 1.
- R6: `rd_half` equals `ofs[8]` of the accepted request when `big_page` is 1, and 0 when `big_page` is 0. It holds that value until the next request is accepted.
- R7: After the last byte, the block waits until `rdy` is high. `done` is not asserted while `rdy` is low.
- R8: `done` is a single-cycle pulse, given in the cycle after `rdy` is seen high in the wait state. `busy` is already low in that cycle.
- R9: A `start` that arrives while `busy` is high is ignored. The bytes of the phase in progress and `rd_half` do not change.
- R10: Mode 00 sends no address byte and goes straight to the ready wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an address phase (taken only when idle) |
| ofs | input | OFS_W | Byte offset into the device |
| mode | input | 2 | Bit 0: send column byte; bit 1: send page bytes |
| big_page | input | 1 | 1 = 512-byte page, 0 = 256-byte page |
| page_bytes | input | 2 | Number of page address bytes, 1 to 3 (0 acts as 1) |
| rdy | input | 1 | Device ready/busy line, 1 = ready |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write enable strobe, active low |
| io | output | 8 | Address byte bus |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_half | output | 1 | 1 = second-half read command implied |

## Verification
The bench targets the 512-byte case with offset bit 8 set. A design that shifts by 8 there sends a page byte that is off by one bit position and also reports the wrong read half. It also runs single page-byte and three page-byte settings, plus the zero setting. A wrong byte counter shows up as a missing or extra strobe, or as a top byte sent to a device that does not need it. The bench holds ready low well past the last byte, so a design that reports completion as soon as the address phase ends is caught. It also presses start in the middle of a phase with a different offset, so a design that relatches the request emits corrupted bytes.

// File: rtl/nand_addr_pkg.sv
package nand_addr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } seq_st_e;

    localparam int MAX_PAGE_BYTES = 3;
    localparam int MAX_ADDR_BYTES = MAX_PAGE_BYTES + 1;
    localparam int IDX_W          = $clog2(MAX_ADDR_BYTES);
    localparam int CNT_W          = IDX_W + 1;

endpackage

// File: rtl/nand_addr_byte_sel.sv
module nand_addr_byte_sel
    import nand_addr_pkg::*;
#(
    parameter int OFS_W = 32
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic             big_page,
    input  logic             has_col,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_o
);
    localparam int PG_W = 8 * MAX_PAGE_BYTES;

    logic [OFS_W-1:0] shifted;
    logic [PG_W-1:0]  page_num;
    logic [7:0]       page_byte [MAX_PAGE_BYTES];
    logic [IDX_W-1:0] page_idx;

    always_comb begin
        shifted  = big_page ? (ofs >> 9) : (ofs >> 8);
        page_num = PG_W'(shifted);
    end

    genvar g;
    generate
        for (g = 0; g < MAX_PAGE_BYTES; g++) begin : g_pb
            assign page_byte[g] = page_num[8*g +: 8];
        end
    endgenerate

    always_comb begin
        page_idx = idx - IDX_W'(has_col);
        if (has_col && idx == '0) begin
            byte_o = ofs[7:0];
        end else if (page_idx < IDX_W'(MAX_PAGE_BYTES)) begin
            byte_o = page_byte[page_idx];
        end else begin
            byte_o = 8'h00;
        end
    end

endmodule

// File: rtl/nand_addr_strobe.sv
module nand_addr_strobe #(
    parameter int STROBE_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic we_n,
    output logic byte_end
);
    localparam int PH_W = $clog2(STROBE_CLKS) + 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(STROBE_CLKS - 1);

    typedef struct packed {
        logic            low;
        logic [PH_W-1:0] cnt;
    } strobe_t;

    strobe_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        byte_end = 1'b0;
        if (!run) begin
            s_d.low = 1'b1;
            s_d.cnt = '0;
        end else if (s_q.cnt == PH_LAST) begin
            s_d.cnt = '0;
            if (s_q.low) begin
                s_d.low = 1'b0;
            end else begin
                s_d.low  = 1'b1;
                byte_end = 1'b1;
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{low: 1'b1, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign we_n = ~(run & s_q.low);

endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
    import nand_addr_pkg::*;
#(
    parameter int OFS_W       = 32,
    parameter int STROBE_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       mode,
    input  logic             big_page,
    input  logic [1:0]       page_bytes,
    input  logic             rdy,
    output logic             ale,
    output logic             we_n,
    output logic [7:0]       io,
    output logic             busy,
    output logic             done,
    output logic             rd_half
);
    typedef struct packed {
        seq_st_e          st;
        logic [OFS_W-1:0] ofs;
        logic             big;
        logic             has_col;
        logic [CNT_W-1:0] nbytes;
        logic [IDX_W-1:0] idx;
        logic             rd1;
        logic             done;
    } seq_t;

    seq_t r_d, r_q;

    logic       byte_end;
    logic       sending;
    logic [7:0] cur_byte;
    logic [1:0] pb_eff;

    assign sending = (r_q.st == ST_SEND);
    assign pb_eff  = (page_bytes == 2'd0) ? 2'd1 : page_bytes;

    nand_addr_strobe #(.STROBE_CLKS(STROBE_CLKS)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (sending),
        .we_n     (we_n),
        .byte_end (byte_end)
    );

    nand_addr_byte_sel #(.OFS_W(OFS_W)) u_sel (
        .ofs      (r_q.ofs),
        .big_page (r_q.big),
        .has_col  (r_q.has_col),
        .idx      (r_q.idx),
        .byte_o   (cur_byte)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.ofs     = ofs;
                    r_d.big     = big_page;
                    r_d.has_col = mode[0];
                    r_d.nbytes  = CNT_W'(mode[0]) + (mode[1] ? CNT_W'(pb_eff) : '0);
                    r_d.idx     = '0;
                    r_d.rd1     = big_page & ofs[8];
                    r_d.st      = (mode == 2'b00) ? ST_WAIT : ST_SEND;
                end
            end
            ST_SEND: begin
                if (byte_end) begin
                    if (CNT_W'(r_q.idx) == r_q.nbytes - 1'b1) begin
                        r_d.st = ST_WAIT;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (rdy) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ale     = sending;
    assign io      = sending ? cur_byte : 8'h00;
    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign rd_half = r_q.rd1;

endmodule

module nand_addr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic rdy,
    input logic ale,
    input logic we_n,
    input logic busy,
    input logic done,
    input logic rd_half
);
    // R1
    strobe_needs_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |-> we_n);

    // R1
    ale_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ale);

    // R2
    strobe_fall_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> ale);

    // R7
    done_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rdy));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(rd_half));
endmodule

bind nand_addr_seq nand_addr_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rdy     (rdy),
    .ale     (ale),
    .we_n    (we_n),
    .busy    (busy),
    .done    (done),
    .rd_half (rd_half)
);

// File: tb/nand_addr_seq_test.sv
`timescale 1ns/1ps
module nand_addr_seq_test;
    localparam int OFS_W  = 32;
    localparam int STROBE = 2;

    typedef struct packed {
        logic [31:0] ofs;
        logic [1:0]  mode;
        logic        big;
        logic [1:0]  pb;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{32'h00AB_CDEF, 2'b11, 1'b0, 2'd3},
        '{32'h0123_4567, 2'b11, 1'b1, 2'd3},
        '{32'h0000_02FF, 2'b01, 1'b1, 2'd2},
        '{32'h0034_5678, 2'b10, 1'b0, 2'd2},
        '{32'h0000_0100, 2'b11, 1'b1, 2'd1},
        '{32'h0000_1122, 2'b11, 1'b0, 2'd0},
        '{32'h1234_5678, 2'b00, 1'b1, 2'd3},
        '{32'hFFFF_FFFF, 2'b10, 1'b1, 2'd3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [OFS_W-1:0] ofs = '0;
    logic [1:0] mode = 2'b00;
    logic big_page = 1'b0;
    logic [1:0] page_bytes = 2'd1;
    logic rdy = 1'b1;
    logic ale, we_n, busy, done, rd_half;
    logic [7:0] io;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] cap [8];
    int cap_n = 0;
    int low_cnt = 0;
    int width_err = 0;
    int ale_err = 0;
    logic prev_we = 1'b1;

    always #2 clk = ~clk;

    nand_addr_seq #(.OFS_W(OFS_W), .STROBE_CLKS(STROBE)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ofs(ofs), .mode(mode),
        .big_page(big_page), .page_bytes(page_bytes), .rdy(rdy),
        .ale(ale), .we_n(we_n), .io(io), .busy(busy), .done(done),
        .rd_half(rd_half)
    );

    // bus monitor: captures a byte at each strobe release
    always @(negedge clk) begin
        if (we_n === 1'b0) begin
            low_cnt = low_cnt + 1;
            if (ale !== 1'b1) ale_err = ale_err + 1;
        end
        if (we_n === 1'b1 && prev_we === 1'b0) begin
            if (cap_n < 8) cap[cap_n] = io;
            cap_n = cap_n + 1;
            if (low_cnt != STROBE) width_err = width_err + 1;
            if (ale !== 1'b1) ale_err = ale_err + 1;
            low_cnt = 0;
        end
        prev_we = we_n;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_count(input vec_t v);
        int pbn = (v.pb == 2'd0) ? 1 : int'(v.pb);
        return int'(v.mode[0]) + (v.mode[1] ? pbn : 0);
    endfunction

    function automatic logic [7:0] exp_byte(input vec_t v, input int i);
        logic [31:0] page = v.big ? (v.ofs >> 9) : (v.ofs >> 8);
        int k;
        if (v.mode[0] && i == 0) return v.ofs[7:0];
        k = i - int'(v.mode[0]);
        return page[8*k +: 8];
    endfunction

    task automatic run_vec(input vec_t v, input int rdy_hold, input bit poke);
        int n;
        @(negedge clk);
        cap_n = 0; width_err = 0; ale_err = 0;
        ofs = v.ofs; mode = v.mode; big_page = v.big; page_bytes = v.pb;
        rdy = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!(busy && !ale) && n < 200) begin
            if (poke && n == 3) begin
                start = 1'b1; ofs = 32'h5A5A_A5A5; big_page = ~v.big;
                mode = 2'b11; page_bytes = 2'd3;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        for (int c = 0; c < rdy_hold; c++) begin
            check("R7 done while not ready", {31'd0, done}, 32'd0);
            check("R7 busy while not ready", {31'd0, busy}, 32'd1);
            @(negedge clk);
        end
        rdy = 1'b1;
        @(negedge clk);
        check("R8 done pulse", {31'd0, done}, 32'd1);
        check("R8 busy low with done", {31'd0, busy}, 32'd0);
        check("R6 read half", {31'd0, rd_half}, {31'd0, v.big & v.ofs[8]});
        @(negedge clk);
        check("R8 done single cycle", {31'd0, done}, 32'd0);
        check("R5 R10 byte count", cap_n, exp_count(v));
        for (int i = 0; i < exp_count(v) && i < 8; i++)
            check("R3 R4 R5 address byte", {24'd0, cap[i]}, {24'd0, exp_byte(v, i)});
        check("R2 strobe width", width_err, 0);
        check("R1 strobe under ale", ale_err, 0);
        check("R1 ale low after phase", {31'd0, ale}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset ale", {31'd0, ale}, 32'd0);
        check("R1 reset we_n", {31'd0, we_n}, 32'd1);
        check("R8 reset busy", {31'd0, busy}, 32'd0);
        check("R8 reset done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(TBL[i], 2, 1'b0);

        // R7: long ready hold after a column+page phase
        run_vec(TBL[1], 12, 1'b0);
        // R9: start pressed mid-phase with a different request
        run_vec(TBL[0], 1, 1'b1);
        run_vec(TBL[4], 1, 1'b1);
        // R5: single page byte with 512-byte page and high offset
        run_vec('{32'h00FE_DC00, 2'b10, 1'b1, 2'd1}, 0, 1'b0);
        // R6: small page ignores offset bit 8
        run_vec('{32'h0000_0180, 2'b11, 1'b0, 2'd1}, 0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule